// File: doc/BRIEF.md
# Byte-Serial Resource Data Port

This block hands a card's resource description to host software one byte at a time. The bytes come from an internal read-only table whose length and contents are set by parameters. Software reaches the block through an indexed register window. One index returns the latched resource byte. A second index returns a status byte whose bit 0 tells software that a fresh byte is waiting. Software polls the status index until that bit is set, then reads the data index. That read moves an internal pointer forward and starts a fetch of the following byte, which takes a parameterised number of clock cycles.

A wake command, presented as a one-cycle pulse from the card's control logic, sends the pointer back to the first byte and restarts the fetch. Past the end of the table the block supplies an end tag, then a zero checksum byte, and then zeros for as long as software keeps reading. The port answers register reads only while the card is in its configuration state, which arrives as an input level.

Top module: `res_stream_port`

## Requirements
- R1: After synchronous reset the status bit 0 reads 0 and the data index reads 0x00. The status bit reads 1 once FETCH_LAT clock edges have passed after the last reset edge.
- R2: A read of index 0x05 returns the ready flag in bit 0, and bits 7:1 always read 0.
- R3: A read of index 0x04 while ready is set returns stream byte k, the k-th byte since reset or wake. For k below ROM_DEPTH this byte equals (ROM_SEED + 29*k) mod 256, and data_oe_o is 1.
- R4: An accepted data read clears ready at the next edge. Ready is set again exactly FETCH_LAT clock edges after the accepting edge.
- R5: A read of index 0x04 while ready is clear returns the byte latched earlier and does not move the pointer.
- R6: Stream byte ROM_DEPTH is 0x79 and every later stream byte is 0x00. The pointer then stays at its last position.
- R7: A wake pulse, whether or not the card is in the configuration state, sends the pointer back to stream byte 0 and clears ready. Ready returns FETCH_LAT edges after the wake edge.
- R8: When a wake pulse and an accepted data read fall in the same cycle, the wake takes priority, and the next byte delivered is stream byte 0.
- R9: While cfg_active_i is 0, reads drive data_oe_o to 0 and rd_data_o to 0x00, and they neither advance the pointer nor clear ready.
- R10: Reads of any index other than 0x04 and 0x05 drive data_oe_o to 0 and rd_data_o to 0x00, and they have no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_active_i | input | 1 | Card is in the configuration state |
| reg_idx_i | input | 8 | Register index of the current access |
| rd_en_i | input | 1 | Read strobe for the indexed register |
| wake_hit_i | input | 1 | One-cycle pulse: wake command addressed to this card |
| rd_data_o | output | 8 | Read data for the indexed register |
| data_oe_o | output | 1 | Port is driving rd_data_o for this read |

## Verification
The two functions that can land in one cycle are a wake pulse and an accepted data read. Both try to change the pointer and the fetch state at the same edge. The bench sets up this collision by raising the wake pulse and the read strobe together while the ready flag is set. The read must still return the byte that was latched before the edge. After the usual fetch latency the stream must then start again at byte 0, and not at the byte after it. A second variant sends a wake pulse while a fetch is still in flight. It checks that the latency count restarts from the wake edge and is not cut short.

// File: rtl/res_stream_pkg.sv
package res_stream_pkg;

    localparam logic [7:0] IDX_RES_DATA = 8'h04;
    localparam logic [7:0] IDX_RES_STAT = 8'h05;
    localparam logic [7:0] END_TAG_BYTE = 8'h79;
    localparam logic [7:0] END_SUM_BYTE = 8'h00;

    typedef struct packed {
        logic data_rd;
        logic stat_rd;
    } res_access_t;

    typedef struct packed {
        logic restart;
        logic step;
    } res_ctrl_t;

    function automatic logic [7:0] rom_value(input int unsigned k, input logic [7:0] seed);
        int unsigned s;
        s = 32'(seed) + k * 32'd29;
        return s[7:0];
    endfunction

    function automatic res_access_t decode_access(input logic cfg, input logic rd,
                                                  input logic [7:0] idx);
        res_access_t a;
        a.data_rd = cfg && rd && (idx == IDX_RES_DATA);
        a.stat_rd = cfg && rd && (idx == IDX_RES_STAT);
        return a;
    endfunction

endpackage

// File: rtl/res_stream_rom.sv
module res_stream_rom
    import res_stream_pkg::*;
#(
    parameter int unsigned DEPTH = 12,
    parameter logic [7:0]  SEED  = 8'h5A,
    parameter int unsigned PW    = 4
) (
    input  logic [PW-1:0] addr_i,
    output logic [7:0]    byte_o
);

    logic [7:0] rom_mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom_mem[g] = rom_value(g, SEED);
    end

    always_comb begin
        byte_o = (addr_i == PW'(DEPTH)) ? END_TAG_BYTE : END_SUM_BYTE;
        for (int k = 0; k < DEPTH; k++) begin
            if (addr_i == PW'(k)) begin
                byte_o = rom_mem[k];
            end
        end
    end

endmodule

// File: rtl/res_stream_ptr.sv
module res_stream_ptr #(
    parameter int unsigned PW   = 4,
    parameter int unsigned LAST = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear_i,
    input  logic          step_i,
    output logic [PW-1:0] ptr_o
);

    logic [PW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            ptr_q <= '0;
        end else if (step_i && (ptr_q != PW'(LAST))) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/res_stream_fetch.sv
module res_stream_fetch #(
    parameter int unsigned LAT = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart_i,
    input  logic [7:0] byte_i,
    output logic       ready_o,
    output logic [7:0] held_o
);

    localparam int unsigned CW = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(LAT - 1);

    logic [CW-1:0] cnt_q;
    logic          ready_q;
    logic [7:0]    held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= CNT_LOAD;
            ready_q <= 1'b0;
            held_q  <= 8'h00;
        end else if (restart_i) begin
            cnt_q   <= CNT_LOAD;
            ready_q <= 1'b0;
        end else if (!ready_q) begin
            if (cnt_q == '0) begin
                held_q  <= byte_i;
                ready_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign ready_o = ready_q;
    assign held_o  = held_q;

endmodule

// File: rtl/res_stream_port.sv
module res_stream_port
    import res_stream_pkg::*;
#(
    parameter int unsigned ROM_DEPTH = 12,
    parameter logic [7:0]  ROM_SEED  = 8'h5A,
    parameter int unsigned FETCH_LAT = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_active_i,
    input  logic [7:0] reg_idx_i,
    input  logic       rd_en_i,
    input  logic       wake_hit_i,
    output logic [7:0] rd_data_o,
    output logic       data_oe_o
);

    localparam int unsigned LAST_POS = ROM_DEPTH + 1;
    localparam int unsigned PW       = $clog2(LAST_POS + 1);

    res_access_t   acc;
    res_ctrl_t     ctl;
    logic          ready_w;
    logic [7:0]    held_w;
    logic [7:0]    fetch_byte;
    logic [PW-1:0] ptr_w;

    assign acc         = decode_access(cfg_active_i, rd_en_i, reg_idx_i);
    assign ctl.step    = acc.data_rd && ready_w && !wake_hit_i;
    assign ctl.restart = wake_hit_i || (acc.data_rd && ready_w);

    res_stream_ptr #(.PW(PW), .LAST(LAST_POS)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .clear_i (wake_hit_i),
        .step_i  (ctl.step),
        .ptr_o   (ptr_w)
    );

    res_stream_rom #(.DEPTH(ROM_DEPTH), .SEED(ROM_SEED), .PW(PW)) u_rom (
        .addr_i (ptr_w),
        .byte_o (fetch_byte)
    );

    res_stream_fetch #(.LAT(FETCH_LAT)) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .restart_i (ctl.restart),
        .byte_i    (fetch_byte),
        .ready_o   (ready_w),
        .held_o    (held_w)
    );

    always_comb begin
        rd_data_o = 8'h00;
        data_oe_o = 1'b0;
        if (acc.data_rd) begin
            rd_data_o = held_w;
            data_oe_o = 1'b1;
        end else if (acc.stat_rd) begin
            rd_data_o = {7'b0, ready_w};
            data_oe_o = 1'b1;
        end
    end

endmodule

// File: rtl/res_stream_port_chk.sv
module res_stream_port_chk #(
    parameter int unsigned LAT  = 3,
    parameter int unsigned LAST = 13,
    parameter int unsigned PW   = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_i,
    input logic [7:0]    idx_i,
    input logic          rd_i,
    input logic          wake_i,
    input logic [7:0]    data_i,
    input logic          oe_i,
    input logic          ready_i,
    input logic [PW-1:0] ptr_i
);

    localparam int unsigned BW = $clog2(LAT + 2);

    logic          data_rd;
    logic          restart;
    logic [BW-1:0] busy_q;

    assign data_rd = cfg_i && rd_i && (idx_i == 8'h04);
    assign restart = wake_i || (data_rd && ready_i);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            busy_q <= '0;
        end else if (!ready_i && (busy_q != BW'(LAT + 1))) begin
            busy_q <= busy_q + 1'b1;
        end
    end

    p_stat_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_i && rd_i && idx_i == 8'h05) |-> (data_i[7:1] == 7'd0 && data_i[0] == ready_i));

    p_ready_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (data_rd && ready_i) |=> !ready_i);

    p_fetch_latency_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_i) |-> (busy_q == BW'(LAT)));

    p_stall_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !ready_i && !wake_i) |=> $stable(ptr_i));

    p_ptr_bound_r6: assert property (@(posedge clk) disable iff (rst)
        ptr_i <= PW'(LAST));

    p_end_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (ptr_i == PW'(LAST) && !wake_i) |=> (ptr_i == PW'(LAST)));

    p_wake_restart_r7: assert property (@(posedge clk) disable iff (rst)
        wake_i |=> (!ready_i && ptr_i == '0));

    p_quiet_outside_cfg_r9: assert property (@(posedge clk) disable iff (rst)
        !cfg_i |-> (!oe_i && data_i == 8'h00));

    p_other_idx_r10: assert property (@(posedge clk) disable iff (rst)
        (idx_i != 8'h04 && idx_i != 8'h05) |-> (!oe_i && data_i == 8'h00));

endmodule

bind res_stream_port res_stream_port_chk #(
    .LAT  (FETCH_LAT),
    .LAST (LAST_POS),
    .PW   (PW)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cfg_i   (cfg_active_i),
    .idx_i   (reg_idx_i),
    .rd_i    (rd_en_i),
    .wake_i  (wake_hit_i),
    .data_i  (rd_data_o),
    .oe_i    (data_oe_o),
    .ready_i (ready_w),
    .ptr_i   (ptr_w)
);

// File: tb/res_stream_port_tb.sv
`timescale 1ns/1ps
module res_stream_port_tb;

    localparam int unsigned DEPTH = 12;
    localparam logic [7:0]  SEED  = 8'h5A;
    localparam int unsigned LAT   = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg = 1'b1;
    logic [7:0] idx = 8'h00;
    logic       rd  = 1'b0;
    logic       wake = 1'b0;
    logic [7:0] rdata;
    logic       oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    res_stream_port #(.ROM_DEPTH(DEPTH), .ROM_SEED(SEED), .FETCH_LAT(LAT)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .cfg_active_i (cfg),
        .reg_idx_i    (idx),
        .rd_en_i      (rd),
        .wake_hit_i   (wake),
        .rd_data_o    (rdata),
        .data_oe_o    (oe)
    );

    function automatic logic [7:0] exp_byte(input int k);
        if (k < DEPTH) return 8'((int'(SEED) + 29 * k) % 256);
        if (k == DEPTH) return 8'h79;
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // At a negedge: one read access, sampled before the edge; returns at next negedge.
    task automatic read_port(input logic [7:0] i, output logic [7:0] d, output logic e);
        idx = i;
        rd  = 1'b1;
        #1;
        d = rdata;
        e = oe;
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0;
    endtask

    // Polls status until bit 0 is set; counts the negedges on which it read 0.
    task automatic poll_ready(output int zeros);
        zeros = 0;
        for (int n = 0; n < 64; n++) begin
            idx = 8'h05;
            rd  = 1'b1;
            #1;
            if (rdata[0]) begin
                chk("R2 status upper bits", int'(rdata[7:1]), 0);
                rd = 1'b0;
                break;
            end
            zeros++;
            @(negedge clk);
        end
        rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       e;
        int         z;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, then ready after LAT edges
        idx = 8'h04; rd = 1'b1; #1;
        chk("R1 data after reset", int'(rdata), 0);
        idx = 8'h05; #1;
        chk("R1 status after reset", int'(rdata), 0);
        poll_ready(z);
        chk("R1 ready latency after reset", z, LAT);

        // R3/R4/R5/R6: sweep the full stream and beyond the end
        for (int k = 0; k < DEPTH + 4; k++) begin
            read_port(8'h04, d, e);
            chk((k < DEPTH) ? "R3 stream byte" : "R6 tail byte", int'(d), int'(exp_byte(k)));
            chk("R3 data oe", int'(e), 1);
            if (k == 4) begin
                read_port(8'h04, d, e);
                chk("R5 stall read returns latched byte", int'(d), int'(exp_byte(k)));
                poll_ready(z);
            end else begin
                poll_ready(z);
                chk("R4 refetch latency", z, LAT);
            end
        end

        // R9: outside config, reads are silent and harmless
        cfg = 1'b0;
        read_port(8'h04, d, e);
        chk("R9 data outside cfg", int'(d), 0);
        chk("R9 oe outside cfg", int'(e), 0);
        read_port(8'h05, d, e);
        chk("R9 status outside cfg", int'(d), 0);

        // R7: wake while outside config
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        cfg  = 1'b1;
        poll_ready(z);
        chk("R7 latency after wake", z, LAT);
        read_port(8'h04, d, e);
        chk("R7 first byte after wake", int'(d), int'(exp_byte(0)));
        poll_ready(z);
        read_port(8'h04, d, e);
        chk("R3 second byte after wake", int'(d), int'(exp_byte(1)));
        poll_ready(z);

        // R9: a read outside config with ready set must not consume a byte
        cfg = 1'b0;
        read_port(8'h04, d, e);
        chk("R9 oe with ready set", int'(e), 0);
        cfg = 1'b1;
        idx = 8'h05; rd = 1'b1; #1;
        chk("R9 ready kept", int'(rdata), 1);
        rd = 1'b0;
        read_port(8'h04, d, e);
        chk("R9 no advance", int'(d), int'(exp_byte(2)));
        poll_ready(z);

        // R10: other indices
        for (int i = 0; i < 16; i++) begin
            if (i == 4 || i == 5) continue;
            read_port(8'(i), d, e);
            chk("R10 other index data", int'(d), 0);
            chk("R10 other index oe", int'(e), 0);
        end
        read_port(8'h04, d, e);
        chk("R10 no advance", int'(d), int'(exp_byte(3)));
        poll_ready(z);

        // R8: wake and accepted read in the same cycle
        idx = 8'h04; rd = 1'b1; wake = 1'b1; #1;
        chk("R8 collision read data", int'(rdata), int'(exp_byte(4)));
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0; wake = 1'b0;
        poll_ready(z);
        chk("R8 latency after collision", z, LAT);
        read_port(8'h04, d, e);
        chk("R8 stream restarts at byte 0", int'(d), int'(exp_byte(0)));

        // R7: wake during an in-flight fetch restarts the count
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        poll_ready(z);
        chk("R7 latency after mid-fetch wake", z, LAT);
        read_port(8'h04, d, e);
        chk("R7 byte 0 after mid-fetch wake", int'(d), int'(exp_byte(0)));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule